// File: doc/BRIEF.md
# Programmable LVDS Lane Bit Mux and Serializer

This block builds the serial lane streams for a one- or two-channel LVDS transmitter. It takes one 28-bit pixel word per channel for every pixel period. The word holds the colour bits together with the sync and data-enable bits. Each channel has four data lanes of seven bit slots. Every slot carries a 5-bit selector that names the bit of the pixel word it transmits, so any panel bit ordering can be programmed through a simple register write port. Two built-in mappings can be loaded with one write: a 24-bit-colour mapping on four lanes and an 18-bit-colour mapping on three lanes.

A 7x bit strobe drives the serializer. The pixel words are sampled on the first strobe of a pixel period. Each lane then emits its seven slots, slot 6 first, one per strobe. The clock lane of each channel emits a fixed seven-bit pattern in the same period. Per-lane and per-clock-lane enables apply to both physical channels. A single-channel mode silences channel 2. A swap control exchanges which pixel word feeds which physical channel.

Serialization needs both an interface enable and a serializer enable. Every write to the lane configuration holds serialization off in hardware for a programmable settling time. The analog drivers and the PLL that makes the strobe sit outside this block.

Top module: `lvds_lane_bitmux`

## Requirements
- R1: The selector for lane l, slot s (l = 0..3, s = 0..6) is written at address 7*l+s from wdata[4:0]. The slot then transmits bit idx of its channel's source pixel word. Selector values 28 to 31 transmit 0.
- R2: A bit_stb while the serializer runs at phase 0 samples pix_a and pix_b. The k-th strobe of a pixel period (k = 0..6) drives each data lane with the bit of slot 6-k, one clock after that strobe. Output and phase hold on cycles without a strobe. After seven strobes the phase returns to 0.
- R3: Each clock lane transmits the pattern 1,1,0,0,0,1,1 over the seven strobes of a pixel period, first bit first.
- R4: The control register (address 28) enables channel 1 data lanes with bits [3:0], channel 2 data lanes with bits [7:4], the channel 1 clock lane with bit 8 and the channel 2 clock lane with bit 9. A disabled lane outputs 0. Bit 10 selects single-channel mode, which forces every channel 2 output to 0.
- R5: With swap clear (control bit 11 = 0), channel 1 transmits pix_a and channel 2 transmits pix_b. With the bit set the sources are exchanged, while the enables stay tied to the physical channel.
- R6: Serialization runs only while control bit 12 (interface enable) and address 29 bit 0 (serializer enable) are both 1. Otherwise every output is 0 from the next clock on, and the phase restarts at 0.
- R7: Any write to a selector, to the control register or to the preset address stops serialization for SETTLE_CYC clocks. Writes to the serializer-enable address do not stop it.
- R8: A write to address 30 loads all selectors at once. With wdata[0] = 1 it loads the 24-bit map: lane 0 = 08,05,04,03,02,01,00; lane 1 = 11,10,0D,0C,0B,0A,09; lane 2 = 1A,19,18,15,14,13,12; lane 3 = 1B,17,16,0F,0E,07,06. With wdata[0] = 0 it loads the 18-bit map: lane 0 = 0A,07,06,05,04,03,02; lane 1 = 13,12,0F,0E,0D,0C,0B; lane 2 = 1A,19,18,17,16,15,14; lane 3 = all 00. Each list gives slots 0 to 6 in hex.
- R9: After reset all selectors and control bits are 0, the serializer is off and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (5) | Register address |
| cfg_wdata | input | DATA_W (32) | Register write data |
| bit_stb | input | 1 | 7x bit strobe, one per serial bit |
| pix_a | input | PIX_W (28) | Pixel word of the first stream |
| pix_b | input | PIX_W (28) | Pixel word of the second stream |
| ch1_data | output | NUM_LANES (4) | Channel 1 data lane bits |
| ch1_clk | output | 1 | Channel 1 clock lane bit |
| ch2_data | output | NUM_LANES (4) | Channel 2 data lane bits |
| ch2_clk | output | 1 | Channel 2 clock lane bit |

## Verification
On every cycle the assertions check the following. Outputs go quiet whenever serialization is stopped. A configuration write stops it at once. The phase wraps after slot 0 and holds without a strobe. Channel 2 stays silent in single-channel mode. The clock lane shows its fixed high and low bits at chosen phases. What each data lane carries in each slot can only be shown by the bench scenarios, which compare every output against a model under these conditions: selector sweeps covering every index value in every slot, swapped and unswapped sources, all lane-enable patterns, both preset maps under walking-one pixels, and the length of the settling window.

// File: rtl/lvds_bitmux_pkg.sv
package lvds_bitmux_pkg;

  localparam int SLOTS = 7;
  localparam int PH_W  = 3;
  localparam int PRESET_SEL_W = 5;

  // Clock lane bit sequence, MSB transmitted first.
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

  // Preset rows, slot 0 in the most significant field.
  localparam logic [34:0] WIDE_L0 = {5'h08, 5'h05, 5'h04, 5'h03, 5'h02, 5'h01, 5'h00};
  localparam logic [34:0] WIDE_L1 = {5'h11, 5'h10, 5'h0D, 5'h0C, 5'h0B, 5'h0A, 5'h09};
  localparam logic [34:0] WIDE_L2 = {5'h1A, 5'h19, 5'h18, 5'h15, 5'h14, 5'h13, 5'h12};
  localparam logic [34:0] WIDE_L3 = {5'h1B, 5'h17, 5'h16, 5'h0F, 5'h0E, 5'h07, 5'h06};
  localparam logic [34:0] NARROW_L0 = {5'h0A, 5'h07, 5'h06, 5'h05, 5'h04, 5'h03, 5'h02};
  localparam logic [34:0] NARROW_L1 = {5'h13, 5'h12, 5'h0F, 5'h0E, 5'h0D, 5'h0C, 5'h0B};
  localparam logic [34:0] NARROW_L2 = {5'h1A, 5'h19, 5'h18, 5'h17, 5'h16, 5'h15, 5'h14};

  function automatic logic [PRESET_SEL_W-1:0] preset_index(input logic wide, input int lane,
                                                             input int slot);
    logic [34:0] row;
    row = '0;
    if (wide) begin
      case (lane)
        0: row = WIDE_L0;
        1: row = WIDE_L1;
        2: row = WIDE_L2;
        3: row = WIDE_L3;
        default: row = '0;
      endcase
    end else begin
      case (lane)
        0: row = NARROW_L0;
        1: row = NARROW_L1;
        2: row = NARROW_L2;
        default: row = '0;
      endcase
    end
    return row[(SLOTS-1-slot)*PRESET_SEL_W +: PRESET_SEL_W];
  endfunction

endpackage

// File: rtl/lvds_bitmux_cfg.sv
module lvds_bitmux_cfg
  import lvds_bitmux_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int SEL_W      = 5,
  parameter int SETTLE_CYC = 200,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [NUM_LANES*SLOTS*SEL_W-1:0]   sel_flat,
  output logic [NUM_LANES-1:0]               lane_en1,
  output logic [NUM_LANES-1:0]               lane_en2,
  output logic                               clk_en1,
  output logic                               clk_en2,
  output logic                               single,
  output logic                               swap,
  output logic                               run,
  output logic                               setup_wr
);

  localparam int NSEL     = NUM_LANES * SLOTS;
  localparam int A_CTRL   = NSEL;
  localparam int A_SER    = NSEL + 1;
  localparam int A_PRESET = NSEL + 2;
  localparam int B_CK1    = 2 * NUM_LANES;
  localparam int B_CK2    = B_CK1 + 1;
  localparam int B_SINGLE = B_CK1 + 2;
  localparam int B_SWAP   = B_CK1 + 3;
  localparam int B_INTF   = B_CK1 + 4;
  localparam int CTRL_W   = B_INTF + 1;
  localparam int CNT_W    = $clog2(SETTLE_CYC + 1);

  logic [NSEL*SEL_W-1:0] sel_q, sel_d;
  logic [CTRL_W-1:0]     ctrl_q, ctrl_d;
  logic                  ser_q, ser_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  hit_sel, hit_ctrl, hit_ser, hit_preset;

  always_comb begin
    hit_sel    = wr_en && (int'(wr_addr) < NSEL);
    hit_ctrl   = wr_en && (int'(wr_addr) == A_CTRL);
    hit_ser    = wr_en && (int'(wr_addr) == A_SER);
    hit_preset = wr_en && (int'(wr_addr) == A_PRESET);
    setup_wr   = hit_sel || hit_ctrl || hit_preset;
  end

  always_comb begin
    sel_d  = sel_q;
    ctrl_d = ctrl_q;
    ser_d  = ser_q;
    cnt_d  = cnt_q;
    if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    if (hit_sel) sel_d[int'(wr_addr)*SEL_W +: SEL_W] = wr_data[SEL_W-1:0];
    if (hit_ctrl) ctrl_d = wr_data[CTRL_W-1:0];
    if (hit_ser) ser_d = wr_data[0];
    if (hit_preset) begin
      for (int i = 0; i < NSEL; i++) begin
        sel_d[i*SEL_W +: SEL_W] = SEL_W'(preset_index(wr_data[0], i / SLOTS, i % SLOTS));
      end
    end
    if (setup_wr) cnt_d = CNT_W'(SETTLE_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      ctrl_q <= '0;
      ser_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      ctrl_q <= ctrl_d;
      ser_q  <= ser_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    sel_flat = sel_q;
    lane_en1 = ctrl_q[NUM_LANES-1:0];
    lane_en2 = ctrl_q[2*NUM_LANES-1:NUM_LANES];
    clk_en1  = ctrl_q[B_CK1];
    clk_en2  = ctrl_q[B_CK2];
    single   = ctrl_q[B_SINGLE];
    swap     = ctrl_q[B_SWAP];
    run      = ser_q && ctrl_q[B_INTF] && (cnt_q == '0);
  end

endmodule

// File: rtl/lvds_bitmux_map.sv
module lvds_bitmux_map
  import lvds_bitmux_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int PIX_W     = 28,
  parameter int SEL_W     = 5
) (
  input  logic [PIX_W-1:0]                 pix,
  input  logic [NUM_LANES*SLOTS*SEL_W-1:0] sel_flat,
  output logic [NUM_LANES*SLOTS-1:0]       slot_bits
);

  localparam int NSEL  = NUM_LANES * SLOTS;
  localparam int EXT_W = 1 << SEL_W;

  logic [EXT_W-1:0] pix_ext;

  // Indices past the pixel word land on zero padding.
  assign pix_ext = EXT_W'(pix);

  for (genvar g = 0; g < NSEL; g++) begin : g_slot
    assign slot_bits[g] = pix_ext[sel_flat[g*SEL_W +: SEL_W]];
  end

endmodule

// File: rtl/lvds_bitmux_ser.sv
module lvds_bitmux_ser
  import lvds_bitmux_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic                         stb,
  input  logic [PH_W-1:0]              phase,
  input  logic [NUM_LANES*SLOTS-1:0]   slot_bits,
  input  logic [NUM_LANES-1:0]         lane_en,
  input  logic                         clk_en,
  output logic [NUM_LANES-1:0]         data_out,
  output logic                         clk_out
);

  localparam int NSEL = NUM_LANES * SLOTS;

  logic [NSEL-1:0]      hold_q, hold_d;
  logic [NUM_LANES-1:0] dat_q, dat_d;
  logic                 ck_q, ck_d;

  always_comb begin
    hold_d = hold_q;
    dat_d  = dat_q;
    ck_d   = ck_q;
    if (!run) begin
      dat_d = '0;
      ck_d  = 1'b0;
    end else if (stb) begin
      if (phase == '0) hold_d = slot_bits;
      for (int l = 0; l < NUM_LANES; l++) begin
        if (phase == '0) dat_d[l] = lane_en[l] & slot_bits[l*SLOTS + SLOTS - 1];
        else             dat_d[l] = lane_en[l] & hold_q[l*SLOTS + SLOTS - 1 - int'(phase)];
      end
      ck_d = clk_en & CLK_PATTERN[SLOTS - 1 - int'(phase)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dat_q  <= '0;
      ck_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      dat_q  <= dat_d;
      ck_q   <= ck_d;
    end
  end

  assign data_out = dat_q;
  assign clk_out  = ck_q;

endmodule

// File: rtl/lvds_lane_bitmux.sv
module lvds_lane_bitmux
  import lvds_bitmux_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int PIX_W      = 28,
  parameter int SETTLE_CYC = 200,
  parameter int DATA_W     = 32,
  localparam int SEL_W     = $clog2(PIX_W),
  localparam int NSEL      = NUM_LANES * SLOTS,
  localparam int ADDR_W    = $clog2(NSEL + 3)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [DATA_W-1:0]    cfg_wdata,
  input  logic                 bit_stb,
  input  logic [PIX_W-1:0]     pix_a,
  input  logic [PIX_W-1:0]     pix_b,
  output logic [NUM_LANES-1:0] ch1_data,
  output logic                 ch1_clk,
  output logic [NUM_LANES-1:0] ch2_data,
  output logic                 ch2_clk
);

  logic                    rst_meta_q, rst_sync_n;
  logic [NSEL*SEL_W-1:0]   sel_flat;
  logic [NUM_LANES-1:0]    lane_en1_w, lane_en2_w;
  logic                    clk_en1_w, clk_en2_w, single_w, swap_w, run_w, setup_w;
  logic [NSEL-1:0]         bits_a, bits_b;
  logic [NSEL-1:0]         src_bits [2];
  logic [NUM_LANES-1:0]    phys_lane_en [2];
  logic                    phys_clk_en [2];
  logic [NUM_LANES-1:0]    ser_data [2];
  logic                    ser_clk [2];
  logic [PH_W-1:0]         phase_q, phase_d;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  lvds_bitmux_cfg #(
    .NUM_LANES (NUM_LANES),
    .SEL_W     (SEL_W),
    .SETTLE_CYC(SETTLE_CYC),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
  ) cfg_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_wr_en),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .sel_flat (sel_flat),
    .lane_en1 (lane_en1_w),
    .lane_en2 (lane_en2_w),
    .clk_en1  (clk_en1_w),
    .clk_en2  (clk_en2_w),
    .single   (single_w),
    .swap     (swap_w),
    .run      (run_w),
    .setup_wr (setup_w)
  );

  lvds_bitmux_map #(.NUM_LANES(NUM_LANES), .PIX_W(PIX_W), .SEL_W(SEL_W)) map_a_i (
    .pix(pix_a), .sel_flat(sel_flat), .slot_bits(bits_a)
  );

  lvds_bitmux_map #(.NUM_LANES(NUM_LANES), .PIX_W(PIX_W), .SEL_W(SEL_W)) map_b_i (
    .pix(pix_b), .sel_flat(sel_flat), .slot_bits(bits_b)
  );

  // Swap picks the source; enables stay with the physical channel.
  always_comb begin
    src_bits[0]     = swap_w ? bits_b : bits_a;
    src_bits[1]     = swap_w ? bits_a : bits_b;
    phys_lane_en[0] = lane_en1_w;
    phys_lane_en[1] = lane_en2_w & {NUM_LANES{~single_w}};
    phys_clk_en[0]  = clk_en1_w;
    phys_clk_en[1]  = clk_en2_w & ~single_w;
  end

  always_comb begin
    phase_d = phase_q;
    if (!run_w) begin
      phase_d = '0;
    end else if (bit_stb) begin
      if (phase_q == PH_W'(SLOTS - 1)) phase_d = '0;
      else                             phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) phase_q <= '0;
    else             phase_q <= phase_d;
  end

  for (genvar c = 0; c < 2; c++) begin : g_chan
    lvds_bitmux_ser #(.NUM_LANES(NUM_LANES)) ser_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .run      (run_w),
      .stb      (bit_stb),
      .phase    (phase_q),
      .slot_bits(src_bits[c]),
      .lane_en  (phys_lane_en[c]),
      .clk_en   (phys_clk_en[c]),
      .data_out (ser_data[c]),
      .clk_out  (ser_clk[c])
    );
  end

  assign ch1_data = ser_data[0];
  assign ch1_clk  = ser_clk[0];
  assign ch2_data = ser_data[1];
  assign ch2_clk  = ser_clk[1];

endmodule

// File: rtl/lvds_bitmux_chk.sv
module lvds_bitmux_chk
  import lvds_bitmux_pkg::*;
#(
  parameter int NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 run,
  input logic                 stb,
  input logic [PH_W-1:0]      phase,
  input logic                 setup_wr,
  input logic                 single,
  input logic                 clk_en1,
  input logic [NUM_LANES-1:0] ch1_data,
  input logic                 ch1_clk,
  input logic [NUM_LANES-1:0] ch2_data,
  input logic                 ch2_clk
);

  p_stopped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (ch1_data == '0 && !ch1_clk && ch2_data == '0 && !ch2_clk));

  p_setup_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    setup_wr |=> !run);

  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stb && phase == PH_W'(SLOTS - 1)) |=> (phase == '0));

  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !stb) |=> $stable(phase));

  p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !stb) |=> ($stable(ch1_data) && $stable(ch2_data) && $stable(ch1_clk)));

  p_clk_first_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stb && clk_en1 && phase == '0) |=> ch1_clk);

  p_clk_mid_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stb && phase == PH_W'(3)) |=> !ch1_clk);

  p_single_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (single && $past(single)) |-> (ch2_data == '0 && !ch2_clk));

endmodule

bind lvds_lane_bitmux lvds_bitmux_chk #(.NUM_LANES(NUM_LANES)) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .run     (run_w),
  .stb     (bit_stb),
  .phase   (phase_q),
  .setup_wr(setup_w),
  .single  (single_w),
  .clk_en1 (clk_en1_w),
  .ch1_data(ch1_data),
  .ch1_clk (ch1_clk),
  .ch2_data(ch2_data),
  .ch2_clk (ch2_clk)
);

// File: tb/lvds_lane_bitmux_tb_top.sv
`timescale 1ns/1ps
module lvds_lane_bitmux_tb_top;

  localparam int NL = 4;
  localparam int PW = 28;
  localparam int NSEL = 28;
  localparam int SETTLE = 40;
  localparam int A_CTRL = 28;
  localparam int A_SER = 29;
  localparam int A_PRE = 30;
  localparam logic [6:0] PAT = 7'b1100011;
  localparam int T24 [28] = '{8,5,4,3,2,1,0, 17,16,13,12,11,10,9,
                              26,25,24,21,20,19,18, 27,23,22,15,14,7,6};
  localparam int T18 [28] = '{10,7,6,5,4,3,2, 19,18,15,14,13,12,11,
                              26,25,24,23,22,21,20, 0,0,0,0,0,0,0};

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_wr_en;
  logic [4:0] cfg_addr;
  logic [31:0] cfg_wdata;
  logic bit_stb;
  logic [PW-1:0] pix_a, pix_b;
  logic [NL-1:0] ch1_data, ch2_data;
  logic ch1_clk, ch2_clk;

  int n_cmp = 0;
  int n_bad = 0;
  int sel_m [NSEL];
  logic [12:0] ctrl_m;
  bit ser_m;
  bit run_m;

  always #2.5 clk = ~clk;

  lvds_lane_bitmux #(.NUM_LANES(NL), .PIX_W(PW), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bit_stb(bit_stb), .pix_a(pix_a), .pix_b(pix_b),
    .ch1_data(ch1_data), .ch1_clk(ch1_clk), .ch2_data(ch2_data), .ch2_clk(ch2_clk)
  );

  function automatic logic bit_of(logic [PW-1:0] w, int idx);
    return (idx < PW) ? w[idx] : 1'b0;
  endfunction

  function automatic logic [9:0] expect_out(logic [PW-1:0] a, logic [PW-1:0] b, int k);
    logic [PW-1:0] s1, s2;
    logic [NL-1:0] e1, e2;
    logic c1, c2;
    if (!run_m) return '0;
    s1 = ctrl_m[11] ? b : a;
    s2 = ctrl_m[11] ? a : b;
    for (int l = 0; l < NL; l++) begin
      e1[l] = ctrl_m[l] & bit_of(s1, sel_m[l*7 + 6 - k]);
      e2[l] = ctrl_m[4+l] & ~ctrl_m[10] & bit_of(s2, sel_m[l*7 + 6 - k]);
    end
    c1 = ctrl_m[8] & PAT[6-k];
    c2 = ctrl_m[9] & ~ctrl_m[10] & PAT[6-k];
    return {c1, e1, c2, e2};
  endfunction

  task automatic check(string req, logic [9:0] exp);
    logic [9:0] got;
    got = {ch1_clk, ch1_data, ch2_clk, ch2_data};
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    cfg_wr_en = 1'b1;
    cfg_addr  = 5'(a);
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (a < NSEL) begin
      sel_m[a] = int'(d[4:0]);
      run_m = 1'b0;
    end else if (a == A_CTRL) begin
      ctrl_m = d[12:0];
      run_m = 1'b0;
    end else if (a == A_SER) begin
      ser_m = d[0];
      run_m = d[0] & ctrl_m[12];
    end else if (a == A_PRE) begin
      for (int i = 0; i < NSEL; i++) sel_m[i] = d[0] ? T24[i] : T18[i];
      run_m = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (SETTLE + 4) @(negedge clk);
    run_m = ser_m & ctrl_m[12];
  endtask

  task automatic send(logic [PW-1:0] a, logic [PW-1:0] b, bit gap, string req);
    for (int k = 0; k < 7; k++) begin
      pix_a = a;
      pix_b = b;
      bit_stb = 1'b1;
      @(negedge clk);
      check(req, expect_out(a, b, k));
      if (gap) begin
        bit_stb = 1'b0;
        pix_a = ~a;
        pix_b = ~b;
        @(negedge clk);
        check({req, " hold"}, expect_out(a, b, k));
      end
    end
    bit_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_addr = '0;
    cfg_wdata = '0;
    bit_stb = 1'b0;
    pix_a = '0;
    pix_b = '0;
    ctrl_m = '0;
    ser_m = 1'b0;
    run_m = 1'b0;
    for (int i = 0; i < NSEL; i++) sel_m[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: quiet after reset, even with strobes and pixel data
    check("R9 reset outputs", '0);
    send(28'hFFFFFFF, 28'hABCDEF1, 1'b0, "R9 idle after reset");

    // R1 R2 R3 R5: every index in every slot, swap alternating
    wr(A_SER, 32'd1);
    for (int r = 0; r < 32; r++) begin
      for (int i = 0; i < NSEL; i++) wr(i, 32'((r + i) % 32));
      wr(A_CTRL, 32'h13FF | (32'(r % 2) << 11));
      settle();
      send(28'($urandom), 28'($urandom), r[1], "R1 R2 R3 R5 sweep");
      send(28'($urandom), 28'($urandom), ~r[1], "R1 R2 R3 R5 sweep");
    end

    // R4: lane enable patterns, clock enables, single-channel mode
    for (int i = 0; i < NSEL; i++) wr(i, 32'(i));
    for (int m = 0; m < 16; m++) begin
      wr(A_CTRL, 32'(m) | (32'((~m) & 15) << 4) | (32'(m % 2) << 8) |
                 (32'((m / 2) % 2) << 9) | (32'((m / 4) % 2) << 10) | 32'h1000);
      settle();
      send(28'($urandom), 28'($urandom), 1'b0, "R4 enables");
    end

    // R6: interface enable off, then serializer enable off and back on
    wr(A_CTRL, 32'h03FF);
    settle();
    send(28'hFFFFFFF, 28'hFFFFFFF, 1'b0, "R6 interface off");
    wr(A_CTRL, 32'h13FF);
    settle();
    send(28'h5A5A5A5, 28'hA5A5A5A, 1'b0, "R6 running");
    wr(A_SER, 32'd0);
    send(28'hFFFFFFF, 28'hFFFFFFF, 1'b0, "R6 serializer off");
    wr(A_SER, 32'd1);
    send(28'h1234567, 28'h7654321, 1'b1, "R6 restart at phase 0");

    // R7: settling window after a control write and after a selector write
    wr(A_CTRL, 32'h13FF);
    send(28'hFFFFFFF, 28'hFFFFFFF, 1'b0, "R7 held off after control write");
    send(28'hFFFFFFF, 28'hFFFFFFF, 1'b0, "R7 held off after control write");
    settle();
    send(28'hFFFFFFF, 28'h0F0F0F0, 1'b0, "R7 active after settling");
    wr(5, 32'd3);
    send(28'hFFFFFFF, 28'hFFFFFFF, 1'b1, "R7 held off after selector write");
    settle();
    send(28'h0FFFFFF, 28'hFFFFFF0, 1'b0, "R7 active after settling");

    // R8: both preset maps under walking-one pixels
    wr(A_PRE, 32'd1);
    settle();
    for (int b = 0; b < PW; b++) send(28'(1) << b, 28'(1) << ((b + 7) % PW), 1'b0, "R8 wide preset");
    wr(A_PRE, 32'd0);
    settle();
    for (int b = 0; b < PW; b++) send(28'(1) << b, 28'(1) << ((b + 3) % PW), 1'b0, "R8 narrow preset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule